// File: doc/BRIEF.md
# UART Register and Interrupt Front End

This block is the register side of a simple character UART that has no FIFOs. A processor reaches it over a word-addressed bus with separate read and write strobes, a register index and 32-bit data. The bus index counts words, so the byte address of a register is its index shifted left by two. Writing the data register sends its low byte out on a one-cycle transmit strobe. Incoming bytes arrive on a valid/ready receive stream and land in a single holding register.

The block keeps the line status, interrupt enable, interrupt identification and modem status views. Parity, framing and break conditions and the modem status bits come in as inputs from the serial engine, which lies outside this block. Pending causes are resolved in a fixed four-level priority into an identification code, and that code drives one level-sensitive interrupt line.

Register indices: 0 data (read: received byte, write: transmit), 1 interrupt enable, 2 interrupt identification (read only), 3 line status (read only), 4 modem status (read only). Indices 5 and above are unmapped. Read data appears on `rdData` in the cycle after the read strobe. Side effects of a read take effect at that same edge.

Top module: `uart_fe_top`

## Requirements
- R1: After reset, line status reads 0x60 (bit 5 holding-empty and bit 6 transmitter-empty set, all other bits zero), interrupt enable reads 0, identification reads 0x1, `irq` is low and `rxReady` is high.
- R2: A byte accepted on the receive stream is stored in the holding register and sets data-ready (line status bit 0). `rxReady` always equals the inverse of data-ready.
- R3: Reading index 0 returns the held byte in bits 7:0 and clears data-ready, so `rxReady` is high in the following cycle.
- R4: A byte that arrives while data-ready is set still replaces the held byte and sets overrun (line status bit 1). Overrun stays set until line status is read, and that read returns it as set.
- R5: Writing index 0 raises `txValid` for exactly one cycle, with `txByte` equal to bits 7:0 of the write data.
- R6: Index 1 stores bits 3:0 of the write data (bit 0 receive-data, bit 1 transmit-empty, bit 2 line-status, bit 3 modem). It reads back with bits 31:4 zero.
- R7: When any of overrun, parity (bit 2), framing (bit 3) or break (bit 4) is set and enable bit 2 is set, the identification register reads 0x6, whatever other causes are pending.
- R8: Below that, the causes in order are: data-ready with enable bit 0 (0x4), holding-empty with enable bit 1 (0x2), and any of `modemIn[3:0]` with enable bit 3 (0x0).
- R9: With no enabled cause, identification reads 0x1 (bit 0 = nothing pending) and `irq` is low. Otherwise `irq` is high.
- R10: Line status bits 4:2 follow `rxErr[2:0]` (break, framing, parity), and index 4 reads `modemIn` in bits 7:0.
- R11: Writes to indices 2, 3, 4 or to unmapped indices change no state, and reads of unmapped indices return 0. Each such access raises `accessErr` for one cycle.
- R12: When a receive byte and a read of index 0 fall in the same cycle, the read returns the old byte, the new byte is stored, data-ready stays set and overrun is not raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| regIdx | input | IDX_W | Register word index |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, valid the cycle after `rdEn` |
| accessErr | output | 1 | One-cycle pulse on an illegal access |
| txValid | output | 1 | One-cycle transmit byte strobe |
| txByte | output | 8 | Transmit byte |
| rxValid | input | 1 | Receive byte valid |
| rxByte | input | 8 | Receive byte |
| rxReady | output | 1 | High while the holding register is empty |
| rxErr | input | 3 | Break, framing and parity status levels |
| modemIn | input | 8 | Modem status bits |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its defaults: a 32-bit data bus and a 3-bit index. With that index every value from 0 to 7 can be driven, so the three unmapped indices are exercised along with the five mapped ones, and the upper 24 bits of the write data are filled with random values to show that they are dropped. Random traffic with mostly-clear error inputs lets each of the four interrupt levels win at some point. Directed cases cover overrun and the receive that collides with a read.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
  localparam int BYTE_W   = 8;
  localparam int IDX_DATA = 0;
  localparam int IDX_IEN  = 1;
  localparam int IDX_IDENT = 2;
  localparam int IDX_LINE = 3;
  localparam int IDX_MODEM = 4;
  localparam int NUM_REGS = 5;

  // line status bit positions
  localparam int LS_READY = 0;
  localparam int LS_OVER  = 1;
  localparam int LS_HOLDE = 5;
  localparam int LS_EMPTY = 6;

  // enable bit positions
  localparam int EN_RXD  = 0;
  localparam int EN_TXE  = 1;
  localparam int EN_LINE = 2;
  localparam int EN_MDM  = 3;

  typedef struct packed {
    logic rdData;
    logic rdEnable;
    logic rdIdent;
    logic rdLine;
    logic rdModem;
    logic wrData;
    logic wrEnable;
  } stb_t;
endpackage

// File: rtl/uart_fe_ctrl.sv
module uart_fe_ctrl
  import uart_fe_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdEn,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] regIdx,
  output stb_t             stb,
  output logic             accessErr
);
  logic badAccess;

  always_comb begin
    stb = '0;
    badAccess = 1'b0;
    if (rdEn) begin
      if (int'(regIdx) == IDX_DATA)       stb.rdData   = 1'b1;
      else if (int'(regIdx) == IDX_IEN)   stb.rdEnable = 1'b1;
      else if (int'(regIdx) == IDX_IDENT) stb.rdIdent  = 1'b1;
      else if (int'(regIdx) == IDX_LINE)  stb.rdLine   = 1'b1;
      else if (int'(regIdx) == IDX_MODEM) stb.rdModem  = 1'b1;
      else                                badAccess    = 1'b1;
    end
    if (wrEn) begin
      if (int'(regIdx) == IDX_DATA)      stb.wrData   = 1'b1;
      else if (int'(regIdx) == IDX_IEN)  stb.wrEnable = 1'b1;
      else                               badAccess    = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) accessErr <= 1'b0;
    else       accessErr <= badAccess;
  end
endmodule

// File: rtl/uart_fe_prio.sv
module uart_fe_prio
  import uart_fe_pkg::*;
(
  input  logic [BYTE_W-1:0] lineStat,
  input  logic [3:0]        ienReg,
  input  logic [3:0]        modemLow,
  output logic [2:0]        ident,
  output logic              irq
);
  logic [1:0] causeId;
  logic       pending;

  always_comb begin
    pending = 1'b1;
    causeId = 2'b00;
    if ((|lineStat[4:1]) && ienReg[EN_LINE])           causeId = 2'b11;
    else if (lineStat[LS_READY] && ienReg[EN_RXD])     causeId = 2'b10;
    else if (lineStat[LS_HOLDE] && ienReg[EN_TXE])     causeId = 2'b01;
    else if ((|modemLow) && ienReg[EN_MDM])            causeId = 2'b00;
    else                                               pending = 1'b0;
  end

  assign ident = {causeId, ~pending};
  assign irq   = pending;
endmodule

// File: rtl/uart_fe_dp.sv
module uart_fe_dp
  import uart_fe_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  stb_t              stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        ident,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [2:0]        rxErr,
  input  logic [BYTE_W-1:0] modemIn,
  output logic [DATA_W-1:0] rdData,
  output logic              txValid,
  output logic [BYTE_W-1:0] txByte,
  output logic              rxReady,
  output logic [BYTE_W-1:0] lineStat,
  output logic [3:0]        ienReg
);
  logic [BYTE_W-1:0] rxHold;
  logic              dataRdy;
  logic              overrun;
  logic              holdEmpty;
  logic              txEmpty;
  logic [DATA_W-1:0] rdMux;
  logic              unusedHigh;

  assign unusedHigh = ^wrData[DATA_W-1:BYTE_W];
  assign lineStat = {1'b0, txEmpty, holdEmpty, rxErr, overrun, dataRdy};
  assign rxReady  = ~dataRdy;

  always_comb begin
    rdMux = '0;
    if (stb.rdData)   rdMux[BYTE_W-1:0] = rxHold;
    if (stb.rdEnable) rdMux[3:0]        = ienReg;
    if (stb.rdIdent)  rdMux[2:0]        = ident;
    if (stb.rdLine)   rdMux[BYTE_W-1:0] = lineStat;
    if (stb.rdModem)  rdMux[BYTE_W-1:0] = modemIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxHold    <= '0;
      dataRdy   <= 1'b0;
      overrun   <= 1'b0;
      holdEmpty <= 1'b1;
      txEmpty   <= 1'b1;
      ienReg    <= '0;
      txValid   <= 1'b0;
      txByte    <= '0;
      rdData    <= '0;
    end else begin
      holdEmpty <= holdEmpty;
      txEmpty   <= txEmpty;
      rdData    <= rdMux;
      txValid   <= stb.wrData;
      if (stb.wrData)   txByte <= wrData[BYTE_W-1:0];
      if (stb.wrEnable) ienReg <= wrData[3:0];
      if (stb.rdLine)   overrun <= 1'b0;
      if (rxValid) begin
        rxHold  <= rxByte;
        dataRdy <= 1'b1;
        if (dataRdy && !stb.rdData) overrun <= 1'b1;
      end else if (stb.rdData) begin
        dataRdy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_fe_top.sv
module uart_fe_top
  import uart_fe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              accessErr,
  output logic              txValid,
  output logic [7:0]        txByte,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  output logic              rxReady,
  input  logic [2:0]        rxErr,
  input  logic [7:0]        modemIn,
  output logic              irq
);
  stb_t              stb;
  logic [2:0]        ident;
  logic [BYTE_W-1:0] lineStat;
  logic [3:0]        ienReg;

  uart_fe_ctrl #(.IDX_W(IDX_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn),
    .regIdx(regIdx), .stb(stb), .accessErr(accessErr)
  );

  uart_fe_dp #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .ident(ident),
    .rxValid(rxValid), .rxByte(rxByte), .rxErr(rxErr), .modemIn(modemIn),
    .rdData(rdData), .txValid(txValid), .txByte(txByte), .rxReady(rxReady),
    .lineStat(lineStat), .ienReg(ienReg)
  );

  uart_fe_prio i_prio (
    .lineStat(lineStat), .ienReg(ienReg), .modemLow(modemIn[3:0]),
    .ident(ident), .irq(irq)
  );
endmodule

// File: rtl/uart_fe_chk.sv
module uart_fe_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic              wrEn,
  input logic [IDX_W-1:0]  regIdx,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              accessErr,
  input logic              txValid,
  input logic [7:0]        txByte,
  input logic              rxValid,
  input logic              rxReady
);
  // R2
  rx_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && rxReady |=> !rxReady);

  // R3
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && !wrEn && regIdx == '0 && !rxValid |=> rxReady);

  // R5
  tx_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !rdEn && regIdx == '0 |=> txValid && txByte == $past(wrData[7:0]));

  // R5
  tx_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && regIdx == '0) |=> !txValid);

  // R11
  bad_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && !wrEn && int'(regIdx) > 4 |=> accessErr && rdData == '0);
endmodule

bind uart_fe_top uart_fe_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .regIdx(regIdx),
  .wrData(wrData), .rdData(rdData), .accessErr(accessErr),
  .txValid(txValid), .txByte(txByte), .rxValid(rxValid), .rxReady(rxReady)
);

// File: tb/test_uart_fe_top.sv
`timescale 1ns/1ps
module test_uart_fe_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdEn = 1'b0, wrEn = 1'b0;
  logic [2:0]  regIdx = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        accessErr, txValid, rxReady, irq;
  logic [7:0]  txByte;
  logic        rxValid = 1'b0;
  logic [7:0]  rxByte = '0;
  logic [2:0]  rxErr = '0;
  logic [7:0]  modemIn = '0;

  int checks = 0, errors = 0;
  logic       mDr = 0, mOe = 0;
  logic [7:0] mHold = 0;
  logic [3:0] mIen = 0;

  always #2 clk = ~clk;

  uart_fe_top #(.DATA_W(32), .IDX_W(3)) i_uart_fe_top (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .regIdx(regIdx),
    .wrData(wrData), .rdData(rdData), .accessErr(accessErr),
    .txValid(txValid), .txByte(txByte), .rxValid(rxValid), .rxByte(rxByte),
    .rxReady(rxReady), .rxErr(rxErr), .modemIn(modemIn), .irq(irq)
  );

  function automatic logic [7:0] expLine();
    return {1'b0, 1'b1, 1'b1, rxErr, mOe, mDr};
  endfunction

  function automatic logic [2:0] expIdent();
    logic [7:0] ls = expLine();
    if ((|ls[4:1]) && mIen[2]) return 3'h6;
    if (mDr && mIen[0])        return 3'h4;
    if (mIen[1])               return 3'h2;
    if ((|modemIn[3:0]) && mIen[3]) return 3'h0;
    return 3'h1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busRead(input logic [2:0] idx, output logic [31:0] val, output logic err);
    @(negedge clk); rdEn = 1; regIdx = idx;
    @(negedge clk); val = rdData; err = accessErr; rdEn = 0;
  endtask

  task automatic busWrite(input logic [2:0] idx, input logic [31:0] val, output logic err);
    @(negedge clk); wrEn = 1; regIdx = idx; wrData = val;
    @(negedge clk); err = accessErr; wrEn = 0;
  endtask

  task automatic sendRx(input logic [7:0] b);
    @(negedge clk); rxValid = 1; rxByte = b;
    @(negedge clk); rxValid = 0;
    if (mDr) mOe = 1;
    mDr = 1; mHold = b;
  endtask

  task automatic checkIdent(string req);
    logic [31:0] v; logic e;
    busRead(3'd2, v, e);
    chk(req, v, {29'd0, expIdent()});
    chk("R9 irq level", {31'd0, irq}, {31'd0, expIdent() != 3'h1});
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic e;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 rxReady", {31'd0, rxReady}, 1);
    busRead(3'd3, v, e); chk("R1 line", v, 32'h60);
    busRead(3'd1, v, e); chk("R1 enable", v, 0);
    busRead(3'd2, v, e); chk("R1 ident", v, 1);

    // R5 transmit
    @(negedge clk); wrEn = 1; regIdx = 0; wrData = 32'hABCD_EF12;
    @(negedge clk); wrEn = 0;
    chk("R5 txValid", {31'd0, txValid}, 1);
    chk("R5 txByte", {24'd0, txByte}, 32'h12);
    @(negedge clk); chk("R5 single pulse", {31'd0, txValid}, 0);

    // R6 enable width
    busWrite(3'd1, 32'hFFFF_FFFF, e); mIen = 4'hF;
    busRead(3'd1, v, e); chk("R6 enable readback", v, 32'hF);
    busWrite(3'd1, 32'h0, e); mIen = 0;

    // R11 illegal accesses
    busWrite(3'd3, 32'hFF, e); chk("R11 wr ro err", {31'd0, e}, 1);
    busWrite(3'd6, 32'hFF, e); chk("R11 wr unmapped err", {31'd0, e}, 1);
    busWrite(3'd2, 32'hFF, e); chk("R11 wr ident err", {31'd0, e}, 1);
    busRead(3'd3, v, e); chk("R11 line unchanged", v, 32'h60);
    chk("R11 legal read no err", {31'd0, e}, 0);
    busRead(3'd7, v, e); chk("R11 unmapped read data", v, 0);
    chk("R11 unmapped read err", {31'd0, e}, 1);

    // R2 R3 receive
    sendRx(8'h5A);
    chk("R2 rxReady low", {31'd0, rxReady}, 0);
    busRead(3'd3, v, e); chk("R2 data ready", v, 32'h61);
    busRead(3'd0, v, e); chk("R3 read byte", v, 32'h5A); mDr = 0;
    chk("R3 rxReady high", {31'd0, rxReady}, 1);

    // R4 overrun
    sendRx(8'h11); sendRx(8'h22);
    busRead(3'd3, v, e); chk("R4 overrun set", v, 32'h63); mOe = 0;
    busRead(3'd3, v, e); chk("R4 overrun cleared", v, 32'h61);
    busRead(3'd0, v, e); chk("R4 new byte kept", v, 32'h22); mDr = 0;

    // R12 collision
    sendRx(8'h33);
    @(negedge clk); rdEn = 1; regIdx = 0; rxValid = 1; rxByte = 8'h44;
    @(negedge clk); v = rdData; rdEn = 0; rxValid = 0;
    chk("R12 old byte", v, 32'h33); mHold = 8'h44;
    busRead(3'd3, v, e); chk("R12 ready no overrun", v, 32'h61);
    busRead(3'd0, v, e); chk("R12 new byte", v, 32'h44); mDr = 0;

    // R7 R8 R10 priorities
    busWrite(3'd1, 32'hF, e); mIen = 4'hF;
    @(negedge clk); rxErr = 3'b010; modemIn = 8'hA5;
    sendRx(8'h77);
    busRead(3'd3, v, e); chk("R10 framing mirror", v, 32'h69);
    busRead(3'd4, v, e); chk("R10 modem read", v, 32'hA5);
    checkIdent("R7 line status first");
    @(negedge clk); rxErr = 0;
    checkIdent("R8 rx data second");
    busRead(3'd0, v, e); mDr = 0;
    checkIdent("R8 tx empty third");
    busWrite(3'd1, 32'h8, e); mIen = 4'h8;
    checkIdent("R8 modem fourth");
    @(negedge clk); modemIn = 8'hF0;
    checkIdent("R9 none pending");

    // random traffic
    for (int n = 0; n < 600; n++) begin
      int op = $urandom % 7;
      case (op)
        0: begin
          sendRx(8'($urandom));
          chk("R2 rxReady", {31'd0, rxReady}, 0);
        end
        1: begin busRead(3'd0, v, e); chk("R3 rand data", v, {24'd0, mHold}); mDr = 0; end
        2: begin busRead(3'd3, v, e); chk("R4 rand line", v, {24'd0, expLine()}); mOe = 0; end
        3: begin
          logic [31:0] w = $urandom;
          busWrite(3'd1, w, e); mIen = w[3:0];
          busRead(3'd1, v, e); chk("R6 rand enable", v, {28'd0, mIen});
        end
        4: checkIdent("R8 rand ident");
        5: begin
          @(negedge clk);
          rxErr = ($urandom % 6 == 0) ? 3'($urandom) : 3'd0;
          modemIn = 8'($urandom);
          busRead(3'd4, v, e); chk("R10 rand modem", v, {24'd0, modemIn});
        end
        default: begin
          logic [2:0] bad = 3'(5 + $urandom % 3);
          busRead(bad, v, e); chk("R11 rand bad read", {v[30:0], e}, 1);
        end
      endcase
      chk("R9 rand irq", {31'd0, irq}, {31'd0, expIdent() != 3'h1});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule